// File: doc/BRIEF.md
# Sound Output Mute and Routing Controller

This block holds the two control registers that steer a TV sound processor's output stage. One is the switch register, which picks a source for each of four audio outputs. The other is the mute and port register, which sets the polarity of the mute pin and the state of two general-purpose port pins. Both registers are loaded through single-cycle write strobes from a bus front end. From the registers, the external mute pin and the raw stereo and dual-sound detector results, the block produces a per-output routing code, an overall audio mute, gated identification flags and two port pins that can be tri-stated.

Muting depends on the history since reset. A small state machine tracks it with three states.
- `MS_HOLD` is entered on reset. Audio is muted and identification is active.
- `MS_PLAY` is the state in which audio plays.
- `MS_SMUTE` is sound-only mute. Audio is muted and the identification flags stay visible.

The state machine has three transitions.
- `HOLD->PLAY` is taken on a non-zero switch write.
- `PLAY->SMUTE` is taken on a zero switch write.
- `SMUTE->PLAY` is taken on a non-zero switch write.

An active mute pin overrides all three states. It gives a full mute and forces the flags to report mono.

Top module: `snd_route_ctl`

## Requirements
- R1: While `rst` is high, `audio_mute` is 1, `stereo_flag` and `dual_flag` are 0, `route` is all zero, and both ports are driven low (`port_oe`=11, `port_val`=00).
- R2: After reset is released, `audio_mute` stays 1 until a non-zero switch write, and switch writes of 0x00 do not unmute. Identification flags follow the detector inputs during this time.
- R3: A non-zero switch write clears `audio_mute` from the cycle after the write strobe, provided the mute pin is inactive.
- R4: A switch write of 0x00 after unmuting sets `audio_mute` from the next cycle (sound mute), while `stereo_flag`/`dual_flag` keep following `det_stereo`/`det_dual`.
- R5: Control register bit 4 sets the mute pin polarity. At 0 (reset value) the pin is active when low; at 1 it is active when high.
- R6: An active mute pin sets `audio_mute` and forces both identification flags to 0 within two clock edges of the pin change (two-stage synchronizer).
- R7: Control bits 1:0 drive port 0 and bits 3:2 drive port 1. For each pair, 1X tri-states the port (`port_oe`=0), 00 drives low and 01 drives high.
- R8: After reset is released, both ports stay driven low until the control register is written.
- R9: With switch bit 6 clear, output i (route bits 2i+1:2i) carries code 01 (first source) when switch bit i is 0 and code 10 (second source) when it is 1.
- R10: With switch bit 6 set, every output carries code 11 (external input).
- R11: `route_stereo` equals switch bit 5 when bit 6 is clear, and is 0 when bit 6 is set.
- R12: Whenever `audio_mute` is 1, all route codes are 00 (silent).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_sw | input | 1 | Write strobe for the switch register |
| wr_ctl | input | 1 | Write strobe for the mute/port register |
| wr_data | input | 8 | Write data |
| mute_pin | input | 1 | External mute pin, polarity set by control bit 4 |
| det_stereo | input | 1 | Raw stereo detection |
| det_dual | input | 1 | Raw dual-sound detection |
| audio_mute | output | 1 | Overall audio output mute |
| route | output | 8 | Two-bit source code per output, output 0 in bits 1:0 |
| route_stereo | output | 1 | Left/right stereo routing selected |
| stereo_flag | output | 1 | Gated stereo identification |
| dual_flag | output | 1 | Gated dual-sound identification |
| port_oe | output | 2 | Port output enables |
| port_val | output | 2 | Port driven levels |

## Verification
The routing decoder is driven with switch codes that separate the per-output bit mapping from the mode bits. Code 0x1C splits the outputs into pairs and 0x2A alternates them, so swapped bit order shows up. Code 0x1F selects the second source everywhere, and 0x7F checks that external selection overrides the low bits and clears the stereo indicator.

For the mute logic, zero writes are issued both before and after the first non-zero write, which tells the reset hold apart from sound mute. The pin is toggled under both polarities, which shows whether the identification flags are gated for a full mute but not for a sound mute.

Port codes 0x16 and 0x18 each tri-state one port while driving the other, which exposes a swapped field or an inverted enable.

// File: rtl/snd_pkg.sv
package snd_pkg;
    typedef enum logic [1:0] {
        MS_HOLD  = 2'd0,
        MS_PLAY  = 2'd1,
        MS_SMUTE = 2'd2
    } mute_st_t;

    localparam logic [1:0] RT_SILENT = 2'b00;
    localparam logic [1:0] RT_FIRST  = 2'b01;
    localparam logic [1:0] RT_SECOND = 2'b10;
    localparam logic [1:0] RT_EXT    = 2'b11;

    localparam int BIT_STEREO   = 5;
    localparam int BIT_EXTERNAL = 6;
    localparam int BIT_PIN_POL  = 4;
    localparam int PORT_FIELD_W = 2;
endpackage

// File: rtl/snd_ctl_regs.sv
module snd_ctl_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_sw,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] sw_q,
    output logic [DW-1:0] ctl_q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sw_q  <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_sw)  sw_q  <= wr_data;
            if (wr_ctl) ctl_q <= wr_data;
        end
    end
endmodule

// File: rtl/snd_pin_sync.sv
module snd_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic pin_s
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], pin_in};
    end

    assign pin_s = chain[STAGES-1];
endmodule

// File: rtl/snd_mute_fsm.sv
module snd_mute_fsm
    import snd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sw_wr,
    input  logic     sw_zero,
    output logic     play,
    output mute_st_t state
);
    mute_st_t nxt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= MS_HOLD;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            MS_HOLD:  if (sw_wr && !sw_zero) nxt = MS_PLAY;
            MS_PLAY:  if (sw_wr && sw_zero)  nxt = MS_SMUTE;
            MS_SMUTE: if (sw_wr && !sw_zero) nxt = MS_PLAY;
            default:  nxt = MS_HOLD;
        endcase
    end

    always_comb begin
        play = (state == MS_PLAY);
    end
endmodule

// File: rtl/snd_route_dec.sv
module snd_route_dec
    import snd_pkg::*;
#(
    parameter int DW      = 8,
    parameter int NUM_OUT = 4,
    parameter int NUM_PRT = 2
) (
    input  logic [DW-1:0]        sw_q,
    input  logic [DW-1:0]        ctl_q,
    input  logic                 mute,
    output logic [2*NUM_OUT-1:0] route,
    output logic                 stereo_mode,
    output logic [NUM_PRT-1:0]   port_oe,
    output logic [NUM_PRT-1:0]   port_val
);
    logic ext_sel;
    assign ext_sel     = sw_q[BIT_EXTERNAL];
    assign stereo_mode = sw_q[BIT_STEREO] & ~ext_sel;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        always_comb begin
            if (mute)         route[2*i +: 2] = RT_SILENT;
            else if (ext_sel) route[2*i +: 2] = RT_EXT;
            else if (sw_q[i]) route[2*i +: 2] = RT_SECOND;
            else              route[2*i +: 2] = RT_FIRST;
        end
    end

    for (genvar p = 0; p < NUM_PRT; p++) begin : g_port
        localparam int LSB = PORT_FIELD_W * p;
        assign port_oe[p]  = ~ctl_q[LSB+1];
        assign port_val[p] = ~ctl_q[LSB+1] & ctl_q[LSB];
    end
endmodule

// File: rtl/snd_route_ctl.sv
module snd_route_ctl
    import snd_pkg::*;
#(
    parameter int DW          = 8,
    parameter int NUM_OUT     = 4,
    parameter int NUM_PRT     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_sw,
    input  logic                 wr_ctl,
    input  logic [DW-1:0]        wr_data,
    input  logic                 mute_pin,
    input  logic                 det_stereo,
    input  logic                 det_dual,
    output logic                 audio_mute,
    output logic [2*NUM_OUT-1:0] route,
    output logic                 route_stereo,
    output logic                 stereo_flag,
    output logic                 dual_flag,
    output logic [NUM_PRT-1:0]   port_oe,
    output logic [NUM_PRT-1:0]   port_val
);
    logic [DW-1:0] sw_q, ctl_q;
    logic          pin_s, pin_act, play, id_en;
    mute_st_t      state;

    snd_ctl_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_sw(wr_sw), .wr_ctl(wr_ctl),
        .wr_data(wr_data), .sw_q(sw_q), .ctl_q(ctl_q)
    );

    snd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_in(mute_pin), .pin_s(pin_s)
    );

    snd_mute_fsm u_fsm (
        .clk(clk), .rst(rst), .sw_wr(wr_sw), .sw_zero(wr_data == '0),
        .play(play), .state(state)
    );

    always_comb begin
        pin_act     = ctl_q[BIT_PIN_POL] ? pin_s : ~pin_s;
        id_en       = ~rst & ~pin_act;
        audio_mute  = rst | ~play | pin_act;
        stereo_flag = id_en & det_stereo;
        dual_flag   = id_en & det_dual;
    end

    snd_route_dec #(.DW(DW), .NUM_OUT(NUM_OUT), .NUM_PRT(NUM_PRT)) u_dec (
        .sw_q(sw_q), .ctl_q(ctl_q), .mute(audio_mute), .route(route),
        .stereo_mode(route_stereo), .port_oe(port_oe), .port_val(port_val)
    );
endmodule

// File: rtl/snd_route_ctl_chk.sv
module snd_route_ctl_chk #(
    parameter int DW      = 8,
    parameter int NUM_OUT = 4,
    parameter int NUM_PRT = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_sw,
    input logic                 wr_ctl,
    input logic [DW-1:0]        wr_data,
    input logic                 pin_act,
    input logic                 audio_mute,
    input logic [2*NUM_OUT-1:0] route,
    input logic                 stereo_flag,
    input logic                 dual_flag,
    input logic [NUM_PRT-1:0]   port_oe,
    input logic [NUM_PRT-1:0]   port_val
);
    always @(posedge clk) begin
        if (rst) begin
            assert_reset_state_R1: assert (audio_mute && !stereo_flag && !dual_flag
                                            && (&port_oe) && port_val == '0);
        end
    end

    assert_zero_write_mutes_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_sw && wr_data == '0) |=> audio_mute);

    assert_pin_full_mute_R6: assert property (@(posedge clk) disable iff (rst)
        pin_act |-> (audio_mute && !stereo_flag && !dual_flag));

    assert_port_hiz_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && wr_data[1]) |=> !port_oe[0]);

    assert_muted_silent_R12: assert property (@(posedge clk) disable iff (rst)
        audio_mute |-> route == '0);
endmodule

bind snd_route_ctl snd_route_ctl_chk #(.DW(DW), .NUM_OUT(NUM_OUT), .NUM_PRT(NUM_PRT)) u_chk (
    .clk(clk), .rst(rst), .wr_sw(wr_sw), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .pin_act(pin_act), .audio_mute(audio_mute), .route(route),
    .stereo_flag(stereo_flag), .dual_flag(dual_flag),
    .port_oe(port_oe), .port_val(port_val)
);

// File: tb/snd_route_ctl_test.sv
module snd_route_ctl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_sw = 1'b0, wr_ctl = 1'b0;
    logic [7:0] wr_data = '0;
    logic       mute_pin = 1'b1;
    logic       det_stereo = 1'b1, det_dual = 1'b0;
    logic       audio_mute, route_stereo, stereo_flag, dual_flag;
    logic [7:0] route;
    logic [1:0] port_oe, port_val;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    snd_route_ctl uut (
        .clk(clk), .rst(rst), .wr_sw(wr_sw), .wr_ctl(wr_ctl), .wr_data(wr_data),
        .mute_pin(mute_pin), .det_stereo(det_stereo), .det_dual(det_dual),
        .audio_mute(audio_mute), .route(route), .route_stereo(route_stereo),
        .stereo_flag(stereo_flag), .dual_flag(dual_flag),
        .port_oe(port_oe), .port_val(port_val)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_sw(input logic [7:0] d);
        @(negedge clk); wr_sw = 1'b1; wr_data = d;
        @(negedge clk); wr_sw = 1'b0;
    endtask

    task automatic write_ctl(input logic [7:0] d);
        @(negedge clk); wr_ctl = 1'b1; wr_data = d;
        @(negedge clk); wr_ctl = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); mute_pin = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(audio_mute, 1, "R1 mute in reset");
        chk({stereo_flag, dual_flag}, 0, "R1 mono in reset");
        chk(route, 0, "R1 route in reset");
        chk({port_oe, port_val}, 4'b1100, "R1 ports low in reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(audio_mute, 1, "R2 hold after reset");
        chk(stereo_flag, 1, "R2 id active after reset");
        chk({port_oe, port_val}, 4'b1100, "R8 ports low after reset");
        write_sw(8'h00);
        chk(audio_mute, 1, "R2 zero write keeps hold");
    endtask

    task automatic t_routing;
        write_sw(8'h1C);
        chk(audio_mute, 0, "R3 unmute");
        chk(route, 8'hA5, "R9 route 1C");
        chk(route_stereo, 0, "R11 no stereo 1C");
        write_sw(8'h2A);
        chk(route, 8'h99, "R9 route 2A");
        chk(route_stereo, 1, "R11 stereo 2A");
        write_sw(8'h1F);
        chk(route, 8'hAA, "R9 route 1F");
        write_sw(8'h7F);
        chk(route, 8'hFF, "R10 external");
        chk(route_stereo, 0, "R11 external clears stereo");
    endtask

    task automatic t_sound_mute;
        det_stereo = 1'b0; det_dual = 1'b1;
        write_sw(8'h00);
        chk(audio_mute, 1, "R4 sound mute");
        chk(route, 0, "R12 silent route");
        chk({stereo_flag, dual_flag}, 2'b01, "R4 flags visible");
        write_sw(8'h10);
        chk(audio_mute, 0, "R3 unmute again");
        chk(route, 8'h55, "R9 route 10");
    endtask

    task automatic t_pin;
        set_pin(1'b0);
        chk(audio_mute, 1, "R6 pin low mutes");
        chk({stereo_flag, dual_flag}, 0, "R6 forced mono");
        chk(route, 0, "R12 pin mute silent");
        set_pin(1'b1);
        chk(audio_mute, 0, "R6 pin release");
        write_ctl(8'h10);
        chk(audio_mute, 1, "R5 high polarity pin high mutes");
        set_pin(1'b0);
        chk(audio_mute, 0, "R5 high polarity pin low plays");
        chk(dual_flag, 1, "R5 flags back");
    endtask

    task automatic t_ports;
        write_ctl(8'h16);
        chk({port_oe, port_val}, 4'b1010, "R7 p0 hiz p1 high");
        write_ctl(8'h18);
        chk({port_oe, port_val}, 4'b0100, "R7 p0 low p1 hiz");
        write_ctl(8'h15);
        chk({port_oe, port_val}, 4'b1111, "R7 both high");
    endtask

    task automatic t_rereset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(audio_mute, 1, "R1 reset mid play");
        chk({port_oe, port_val}, 4'b1100, "R1 ports reset");
        rst = 1'b0; mute_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk(audio_mute, 1, "R2 hold after second reset");
    endtask

    initial begin
        t_reset();
        t_routing();
        t_sound_mute();
        t_pin();
        t_ports();
        t_rereset();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule